// File: doc/BRIEF.md
# Vector Autocorrelation Engine

This block computes the autocorrelation lags of a vector of signed 16-bit samples. A start strobe copies the whole vector into a resident register, together with the vector length and the number of lags wanted. For each lag k the engine multiplies every sample by the sample k places further along and accumulates the products. It then divides the sum by the vector length and emits the result with its lag index and a one-cycle valid strobe. After the final lag a one-cycle done strobe follows.

The lagged operand never comes from memory a second time. A second copy of the resident vector moves down by one element at the end of every lag, so sample n of the base copy always lines up with sample n+k of the lagged copy. Elements that move in from beyond the end of the vector are zero, so terms past the end contribute nothing. The vector length is a power of two, given as its base-2 logarithm, so the 1/N scaling is an arithmetic right shift. One product is accumulated per clock, and each lag takes N clocks.

Top module: `autocorr_engine`

## Requirements
- R1: While reset is held low, and in the first cycle after it is released, busy, resValid and done are low and resData is zero.
- R2: The result for lag k equals floor((sum over n from 0 to N-k-1 of x[n]*x[n+k]) / N). Samples are signed 16-bit, taken as element i = dataIn[16*i+15:16*i]. Products that would reach past index N-1 count as zero, and the division is an arithmetic right shift by lenLog2.
- R3: Lags come out in ascending order 0, 1, …, K-1. Each has exactly one resValid pulse, and resLag carries its index.
- R4: If start is sampled at clock edge 0, the result for lag k appears after edge (k+1)*N, so valid pulses are spaced N cycles apart.
- R5: done is high for one cycle, in the cycle after the last result, or after edge 1 when no lag is requested. busy is low in that cycle.
- R6: A lag count larger than N is treated as N, and a lag count of zero produces no result, only the done pulse.
- R7: A lenLog2 value above the largest supported length code is treated as that largest code.
- R8: A start while busy is ignored. Changes to dataIn, lenLog2 or lagCount after the start edge do not affect the running job.
- R9: A start presented in the cycle where done is high is accepted, and the next job runs with R2 to R5 timing.
- R10: resData changes only in cycles where resValid is high.
- R11: Vector elements at index N or above have no effect on any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a job when idle |
| lenLog2 | input | 3 | log2 of vector length N |
| lagCount | input | 5 | Number of lags K |
| dataIn | input | 256 | Sample vector, element i at bits 16*i+15 to 16*i |
| busy | output | 1 | A job is in progress |
| resValid | output | 1 | Result strobe |
| resLag | output | 5 | Lag index of the current result |
| resData | output | 32 | Scaled lag result, signed |
| done | output | 1 | Pulse after the final lag |

## Verification
The done pulse of one job and the acceptance of the next start can fall in the same cycle. The bench provokes this by chaining jobs with no idle cycle between them, raising start in the very cycle done is sampled high. It judges the overlap by demanding the full valid timing and exact lag values of the second job. A second overlap, a start raised while a job is in flight, is provoked with altered data and lag count on the inputs. It is judged by checking that the running job's results still match the vector captured at its own start.

// File: rtl/autocorr_pkg.sv
package autocorr_pkg;

  // Strobes from control to datapath, one per datapath action.
  typedef struct packed {
    logic load;    // capture vector into both copies, clear accumulator
    logic accEn;   // add one product into the accumulator
    logic lagEnd;  // last product of a lag: publish, clear, shift lagged copy
  } ctrlStrobes_t;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RUN  = 2'd1,
    S_FIN  = 2'd2
  } engState_t;

endpackage

// File: rtl/autocorr_ctrl.sv
module autocorr_ctrl
  import autocorr_pkg::*;
#(
  parameter int MAX_LOG2 = 4,
  localparam int IDX_W = MAX_LOG2,
  localparam int LAG_W = MAX_LOG2 + 1,
  localparam int LEN_W = $clog2(MAX_LOG2 + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [LEN_W-1:0] lenLog2,
  input  logic [LAG_W-1:0] lagCount,
  output ctrlStrobes_t     strobes,
  output logic [IDX_W-1:0] idx,
  output logic [LEN_W-1:0] lenSel,
  output logic [LEN_W-1:0] loadLen,
  output logic             busy,
  output logic             resValid,
  output logic [LAG_W-1:0] resLag,
  output logic             done
);

  engState_t        state;
  logic [LAG_W-1:0] lag;
  logic [LAG_W-1:0] kEff;
  logic [LAG_W-1:0] nAtStart;
  logic [LAG_W-1:0] kAtStart;
  logic [IDX_W-1:0] nLast;
  logic             idxWrap;
  logic             lastLag;

  // Length code clamp and lag count clamp, evaluated on the start cycle.
  always_comb begin
    loadLen  = (lenLog2 > LEN_W'(MAX_LOG2)) ? LEN_W'(MAX_LOG2) : lenLog2;
    nAtStart = LAG_W'(1) << loadLen;
    kAtStart = (lagCount > nAtStart) ? nAtStart : lagCount;
  end

  always_comb begin
    nLast   = IDX_W'((LAG_W'(1) << lenSel) - LAG_W'(1));
    idxWrap = (idx == nLast);
    lastLag = (lag == (kEff - LAG_W'(1)));
    busy    = (state != S_IDLE);
    strobes.load   = (state == S_IDLE) && start;
    strobes.accEn  = (state == S_RUN);
    strobes.lagEnd = (state == S_RUN) && idxWrap;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      idx      <= '0;
      lag      <= '0;
      kEff     <= '0;
      lenSel   <= '0;
      resValid <= 1'b0;
      resLag   <= '0;
      done     <= 1'b0;
    end else begin
      resValid <= 1'b0;
      done     <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (start) begin
            lenSel <= loadLen;
            kEff   <= kAtStart;
            idx    <= '0;
            lag    <= '0;
            state  <= (kAtStart == '0) ? S_FIN : S_RUN;
          end
        end
        S_RUN: begin
          if (idxWrap) begin
            resValid <= 1'b1;
            resLag   <= lag;
            idx      <= '0;
            if (lastLag) begin
              state <= S_FIN;
            end else begin
              lag <= lag + LAG_W'(1);
            end
          end else begin
            idx <= idx + IDX_W'(1);
          end
        end
        S_FIN: begin
          done  <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/autocorr_dp.sv
module autocorr_dp
  import autocorr_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int MAX_LOG2 = 4,
  localparam int MAX_N  = 1 << MAX_LOG2,
  localparam int IDX_W  = MAX_LOG2,
  localparam int LEN_W  = $clog2(MAX_LOG2 + 1),
  localparam int PROD_W = 2 * SAMPLE_W,
  localparam int ACC_W  = PROD_W + MAX_LOG2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrobes_t               strobes,
  input  logic [IDX_W-1:0]           idx,
  input  logic [LEN_W-1:0]           lenSel,
  input  logic [LEN_W-1:0]           loadLen,
  input  logic [MAX_N*SAMPLE_W-1:0]  dataIn,
  output logic signed [PROD_W-1:0]   resData
);

  logic [MAX_N-1:0][SAMPLE_W-1:0] baseReg;
  logic [MAX_N-1:0][SAMPLE_W-1:0] lagReg;
  logic [MAX_N-1:0][SAMPLE_W-1:0] loadVal;
  logic [MAX_N-1:0][SAMPLE_W-1:0] shiftVal;

  // Per-lane load masking and one-place downward shift of the lagged copy.
  for (genvar i = 0; i < MAX_N; i++) begin : gLane
    assign loadVal[i] = (32'(i) < (32'd1 << loadLen)) ?
                        dataIn[i*SAMPLE_W +: SAMPLE_W] : '0;
    if (i == MAX_N - 1) begin : gTop
      assign shiftVal[i] = '0;
    end else begin : gMid
      assign shiftVal[i] = lagReg[i+1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseReg <= '0;
      lagReg  <= '0;
    end else if (strobes.load) begin
      baseReg <= loadVal;
      lagReg  <= loadVal;
    end else if (strobes.lagEnd) begin
      lagReg <= shiftVal;
    end
  end

  logic signed [PROD_W-1:0] opA;
  logic signed [PROD_W-1:0] opB;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  acc;
  logic signed [ACC_W-1:0]  accSum;
  logic signed [ACC_W-1:0]  scaled;

  always_comb begin
    opA    = PROD_W'($signed(baseReg[idx]));
    opB    = PROD_W'($signed(lagReg[idx]));
    prod   = opA * opB;
    accSum = acc + ACC_W'(prod);
    scaled = accSum >>> lenSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc     <= '0;
      resData <= '0;
    end else begin
      if (strobes.load || strobes.lagEnd) begin
        acc <= '0;
      end else if (strobes.accEn) begin
        acc <= accSum;
      end
      if (strobes.lagEnd) begin
        resData <= PROD_W'(scaled);
      end
    end
  end

endmodule

// File: rtl/autocorr_engine.sv
module autocorr_engine
  import autocorr_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int MAX_LOG2 = 4,
  localparam int MAX_N  = 1 << MAX_LOG2,
  localparam int IDX_W  = MAX_LOG2,
  localparam int LAG_W  = MAX_LOG2 + 1,
  localparam int LEN_W  = $clog2(MAX_LOG2 + 1),
  localparam int PROD_W = 2 * SAMPLE_W
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      start,
  input  logic [LEN_W-1:0]          lenLog2,
  input  logic [LAG_W-1:0]          lagCount,
  input  logic [MAX_N*SAMPLE_W-1:0] dataIn,
  output logic                      busy,
  output logic                      resValid,
  output logic [LAG_W-1:0]          resLag,
  output logic signed [PROD_W-1:0]  resData,
  output logic                      done
);

  ctrlStrobes_t     strobes;
  logic [IDX_W-1:0] idx;
  logic [LEN_W-1:0] lenSel;
  logic [LEN_W-1:0] loadLen;

  autocorr_ctrl #(.MAX_LOG2(MAX_LOG2)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .lenLog2(lenLog2),
    .lagCount(lagCount), .strobes(strobes), .idx(idx), .lenSel(lenSel),
    .loadLen(loadLen), .busy(busy), .resValid(resValid), .resLag(resLag),
    .done(done)
  );

  autocorr_dp #(.SAMPLE_W(SAMPLE_W), .MAX_LOG2(MAX_LOG2)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .idx(idx), .lenSel(lenSel),
    .loadLen(loadLen), .dataIn(dataIn), .resData(resData)
  );

endmodule

// File: rtl/autocorr_engine_chk.sv
module autocorr_engine_chk #(
  parameter int SAMPLE_W = 16,
  parameter int MAX_LOG2 = 4,
  localparam int LAG_W  = MAX_LOG2 + 1,
  localparam int PROD_W = 2 * SAMPLE_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              resValid,
  input logic [LAG_W-1:0]  resLag,
  input logic [PROD_W-1:0] resData,
  input logic              done
);

  // R5: done is separate from results and the engine is idle while it shows
  a_r5_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!resValid && !busy));

  // R5: done lasts one cycle
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: start from idle is taken on the next edge
  a_r8_start_taken: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  // R3: results only appear inside a job
  a_r3_valid_in_job: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> busy);

  // R10: result value moves only with its strobe
  a_r10_data_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(resData) |-> resValid);

endmodule

bind autocorr_engine autocorr_engine_chk #(
  .SAMPLE_W(SAMPLE_W), .MAX_LOG2(MAX_LOG2)
) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .resValid(resValid),
  .resLag(resLag), .resData(resData), .done(done)
);

// File: tb/autocorr_engine_tb.sv
module autocorr_engine_tb;
  localparam int SW   = 16;
  localparam int ML   = 4;
  localparam int MN   = 1 << ML;
  localparam int LAGW = ML + 1;
  localparam int LENW = $clog2(ML + 1);
  localparam int VW   = MN * SW;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            start = 1'b0;
  logic [LENW-1:0] lenLog2 = '0;
  logic [LAGW-1:0] lagCount = '0;
  logic [VW-1:0]   dataIn = '0;
  logic            busy;
  logic            resValid;
  logic [LAGW-1:0] resLag;
  logic signed [2*SW-1:0] resData;
  logic            done;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  autocorr_engine #(.SAMPLE_W(SW), .MAX_LOG2(ML)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .lenLog2(lenLog2),
    .lagCount(lagCount), .dataIn(dataIn), .busy(busy), .resValid(resValid),
    .resLag(resLag), .resData(resData), .done(done)
  );

  task automatic check(input bit ok, input string tag, input longint act,
                       input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint expLag(input logic [VW-1:0] v, input int lenE,
                                    input int k);
    longint s = 0;
    int n = 1 << lenE;
    for (int i = 0; i + k < n; i++) begin
      s += longint'($signed(v[i*SW +: SW])) * longint'($signed(v[(i+k)*SW +: SW]));
    end
    return s >>> lenE;
  endfunction

  function automatic logic [VW-1:0] randVec();
    logic [VW-1:0] v;
    for (int i = 0; i < MN; i++) v[i*SW +: SW] = SW'($urandom());
    return v;
  endfunction

  // Called at a negedge; returns at the negedge of the done cycle.
  task automatic runJob(input logic [VW-1:0] v, input int lenL, input int k,
                        input bit poke, input string tag);
    int lenE = (lenL > ML) ? ML : lenL;
    int n    = 1 << lenE;
    int kE   = (k > n) ? n : k;
    int last = kE * n + 1;
    start    = 1'b1;
    dataIn   = v;
    lenLog2  = LENW'(lenL);
    lagCount = LAGW'(k);
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      start    = 1'b1;
      dataIn   = ~v;
      lagCount = LAGW'(MN);
      lenLog2  = LENW'(ML);
    end
    for (int c = 1; c <= last; c++) begin
      bit expV;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      expV = (c % n == 0) && (c < last);
      check(resValid == expV, {tag, " R4 valid timing"}, longint'(resValid),
            longint'(expV));
      if (expV && resValid) begin
        check(int'(resLag) == c / n - 1, {tag, " R3 lag index"},
              longint'(resLag), longint'(c / n - 1));
        check(longint'(resData) == expLag(v, lenE, c / n - 1),
              {tag, " R2 R11 lag value"}, longint'(resData),
              expLag(v, lenE, c / n - 1));
      end
      check(done == (c == last), {tag, " R5 done"}, longint'(done),
            longint'(c == last));
      if (c == last) check(!busy, {tag, " R5 busy at done"}, longint'(busy), 0);
    end
  endtask

  initial begin
    logic [VW-1:0] v;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    check(!busy && !resValid && !done && resData == 0, "R1 in reset",
          longint'({busy, resValid, done}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !resValid && !done && resData == 0, "R1 after reset",
          longint'({busy, resValid, done}), 0);

    // ramp, N=4, K=4, upper elements random garbage
    v = randVec();
    for (int i = 0; i < 4; i++) v[i*SW +: SW] = SW'(i + 1);
    runJob(v, 2, 4, 1'b0, "R11 ramp");
    @(negedge clk);
    // extreme negative values, full length
    for (int i = 0; i < MN; i++) v[i*SW +: SW] = 16'h8000;
    runJob(v, ML, MN, 1'b0, "R2 extreme");
    @(negedge clk);
    // alternating signs, odd sums to test floor
    for (int i = 0; i < MN; i++) v[i*SW +: SW] = (i % 2 == 0) ? SW'(3) : SW'(-5);
    runJob(v, 3, 5, 1'b0, "R2 floor");
    // lag count clamp, N=1
    runJob(randVec(), 0, 3, 1'b0, "R6 clamp");
    // zero lags
    runJob(randVec(), 2, 0, 1'b0, "R6 zero");
    @(negedge clk);
    // length code clamp
    runJob(randVec(), 7, 2, 1'b0, "R7 len");
    @(negedge clk);
    // start and new inputs during a run
    runJob(randVec(), 3, 3, 1'b1, "R8 poke");
    // back-to-back jobs
    runJob(randVec(), 2, 2, 1'b0, "R9 first");
    runJob(randVec(), 1, 2, 1'b0, "R9 second");

    for (int j = 0; j < 40; j++) begin
      runJob(randVec(), $urandom_range(0, 5), $urandom_range(0, 18),
             1'($urandom_range(0, 1)), "rand");
      if ($urandom_range(0, 1) == 1) @(negedge clk);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule